// File: doc/BRIEF.md
# Ethernet Link/Activity and Speed Indicator Controller

This block turns PHY status into two active-low indicator drives. The first indicator shows link and activity together. It is lit while a valid link exists. When transmit or receive traffic is seen, it goes dark for one fixed interval. It is then held lit for at least one interval before it can go dark again. Traffic seen during either interval is remembered, and it starts the next dark interval as soon as the lit interval ends. The second indicator shows the line speed and the negotiation state.

Each output is a drive-low enable. A 1 means the external open-drain pad pulls the pin low and the indicator is lit. A 0 releases the pin, and the pull-up leaves the indicator dark. The blink interval, in clock cycles, is computed from a clock-frequency parameter and a millisecond parameter as `CLK_HZ * BLINK_MS / 1000`. When the parameter `SIM_TICKS` is nonzero, its value replaces that count. Both outputs are registered and both are dark after reset.

Top module: `led_status_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released with no link, both drive outputs are 0 (indicators dark).
- R2: With link up and no traffic, `lnk_led_drive_o` is 1 from the cycle after link is sampled high.
- R3: A transmit or receive strobe sampled while the indicator is solidly lit makes `lnk_led_drive_o` 0 from the next cycle. It stays 0 for exactly T cycles, where T is `SIM_TICKS` when that is nonzero and `CLK_HZ*BLINK_MS/1000` otherwise.
- R4: Every dark interval is followed by exactly T cycles with `lnk_led_drive_o` = 1, even under continuous traffic.
- R5: A strobe sampled during a dark or lit interval is remembered. The next dark interval then starts in the cycle right after the lit interval ends. Starting a dark interval clears the memory, so one strobe causes at most one further dark interval.
- R6: If no strobe was sampled during a dark interval or the lit interval after it, the output stays at 1 after that lit interval.
- R7: `link_up_i` low makes `lnk_led_drive_o` 0 in the next cycle and aborts any interval in progress. No remembered traffic survives. When link returns without traffic, the output is 1 from the cycle after.
- R8: `spd_led_drive_o` equals `!isolate_i && (speed100_i || aneg_busy_i)` as sampled one cycle earlier. Isolation overrides both speed and negotiation, and negotiation overrides a 10 Mb/s indication.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Valid link detected |
| tx_act_i | input | 1 | Transmit activity strobe |
| rx_act_i | input | 1 | Receive activity strobe |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| aneg_busy_i | input | 1 | Autonegotiation in progress |
| isolate_i | input | 1 | Line isolated |
| lnk_led_drive_o | output | 1 | Link/activity pin drive-low enable (1 = lit) |
| spd_led_drive_o | output | 1 | Speed pin drive-low enable (1 = lit) |

## Verification
Each output comes from a single register, so a change on an input is visible on the outputs one cycle after the clock edge that samples it. A dark interval that begins at edge k releases the pin for edges k through k+T-1, and the lit interval after it ends at edge k+2T-1.

The bench changes its inputs only at falling edges. Its reference model steps once at each rising edge, using the inputs held since the falling edge before. Both outputs are compared with the model at every falling edge, so each result is sampled half a cycle after the edge that produced it. With T set to 5, the bench covers:
- a single strobe;
- a strobe arriving during the dark interval;
- continuous traffic;
- link loss in the middle of an interval.

// File: rtl/led_status_pkg.sv
package led_status_pkg;
    typedef enum logic [1:0] {
        BL_SOLID = 2'd0,
        BL_DARK  = 2'd1,
        BL_HOLD  = 2'd2
    } blink_st_e;
endpackage

// File: rtl/lnk_act_blinker.sv
module lnk_act_blinker
    import led_status_pkg::*;
#(
    parameter int unsigned TICKS = 5,
    localparam int unsigned CNT_W = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up_i,
    input  logic act_i,
    output logic drive_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        blink_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             drive;
    } blink_regs_t;

    blink_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!link_up_i) begin
            r_d.st    = BL_SOLID;
            r_d.cnt   = '0;
            r_d.pend  = 1'b0;
            r_d.drive = 1'b0;
        end else begin
            unique case (r_q.st)
                BL_SOLID: begin
                    if (act_i || r_q.pend) begin
                        r_d.st    = BL_DARK;
                        r_d.cnt   = '0;
                        r_d.pend  = 1'b0;
                        r_d.drive = 1'b0;
                    end else begin
                        r_d.drive = 1'b1;
                    end
                end
                BL_DARK: begin
                    r_d.pend = r_q.pend | act_i;
                    if (r_q.cnt == LAST) begin
                        r_d.st    = BL_HOLD;
                        r_d.cnt   = '0;
                        r_d.drive = 1'b1;
                    end else begin
                        r_d.cnt   = r_q.cnt + 1'b1;
                        r_d.drive = 1'b0;
                    end
                end
                BL_HOLD: begin
                    r_d.pend = r_q.pend | act_i;
                    if (r_q.cnt == LAST) begin
                        r_d.cnt = '0;
                        if (r_q.pend || act_i) begin
                            r_d.st    = BL_DARK;
                            r_d.pend  = 1'b0;
                            r_d.drive = 1'b0;
                        end else begin
                            r_d.st    = BL_SOLID;
                            r_d.drive = 1'b1;
                        end
                    end else begin
                        r_d.cnt   = r_q.cnt + 1'b1;
                        r_d.drive = 1'b1;
                    end
                end
                default: begin
                    r_d.st    = BL_SOLID;
                    r_d.cnt   = '0;
                    r_d.pend  = 1'b0;
                    r_d.drive = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= BL_SOLID;
            r_q.cnt   <= '0;
            r_q.pend  <= 1'b0;
            r_q.drive <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_o = r_q.drive;

    p_nolink_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up_i |=> (!drive_o && r_q.st == BL_SOLID && !r_q.pend));

    p_dark_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_i && r_q.st == BL_DARK && r_q.cnt != LAST) |=> (r_q.st == BL_DARK && !drive_o));

    p_lit_after_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_i && r_q.st == BL_DARK && r_q.cnt == LAST) |=> (r_q.st == BL_HOLD && drive_o));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST);

    p_pend_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BL_DARK && $past(r_q.st) != BL_DARK) |-> !r_q.pend);
endmodule

// File: rtl/spd_indicator.sv
module spd_indicator (
    input  logic clk,
    input  logic rst_n,
    input  logic speed100_i,
    input  logic aneg_busy_i,
    input  logic isolate_i,
    output logic drive_o
);
    logic drive_d, drive_q;

    always_comb begin
        drive_d = 1'b0;
        if (!isolate_i) begin
            if (aneg_busy_i)      drive_d = 1'b1;
            else if (speed100_i)  drive_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= drive_d;
    end

    assign drive_o = drive_q;

    p_iso_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        isolate_i |=> !drive_o);

    p_aneg_lit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (aneg_busy_i && !isolate_i) |=> drive_o);
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl #(
    parameter int unsigned CLK_HZ    = 25_000_000,
    parameter int unsigned BLINK_MS  = 80,
    parameter int unsigned SIM_TICKS = 0,
    localparam longint unsigned RAW_TICKS = (longint'(CLK_HZ) * longint'(BLINK_MS)) / 64'd1000,
    localparam int unsigned TICKS = (SIM_TICKS != 0) ? SIM_TICKS : int'(RAW_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up_i,
    input  logic tx_act_i,
    input  logic rx_act_i,
    input  logic speed100_i,
    input  logic aneg_busy_i,
    input  logic isolate_i,
    output logic lnk_led_drive_o,
    output logic spd_led_drive_o
);
    logic any_act;
    assign any_act = tx_act_i | rx_act_i;

    lnk_act_blinker #(.TICKS(TICKS)) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up_i (link_up_i),
        .act_i     (any_act),
        .drive_o   (lnk_led_drive_o)
    );

    spd_indicator u_spd (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed100_i  (speed100_i),
        .aneg_busy_i (aneg_busy_i),
        .isolate_i   (isolate_i),
        .drive_o     (spd_led_drive_o)
    );
endmodule

// File: tb/led_status_ctrl_test.sv
module led_status_ctrl_test;
    localparam int PERIOD = 10;
    localparam int T = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link = 1'b0, tx = 1'b0, rx = 1'b0, s100 = 1'b0, aneg = 1'b0, iso = 1'b0;
    logic lnk_o, spd_o;

    int vectors = 0;
    int fails = 0;
    string req = "R1";

    int mode = 0;
    int left = 0;
    bit pend = 0;
    bit exp_lnk = 0;
    bit exp_spd = 0;
    int pat = 0;

    always #(PERIOD/2) clk = ~clk;

    led_status_ctrl #(.SIM_TICKS(T)) uut (
        .clk(clk), .rst_n(rst_n), .link_up_i(link), .tx_act_i(tx), .rx_act_i(rx),
        .speed100_i(s100), .aneg_busy_i(aneg), .isolate_i(iso),
        .lnk_led_drive_o(lnk_o), .spd_led_drive_o(spd_o)
    );

    task automatic model_step();
        bit act;
        act = tx | rx;
        if (!rst_n) begin
            mode = 0; pend = 0; exp_lnk = 0; exp_spd = 0;
            return;
        end
        exp_spd = !iso && (s100 || aneg);
        if (!link) begin
            mode = 0; pend = 0; exp_lnk = 0;
        end else if (mode == 0) begin
            if (act) begin mode = 1; left = T; exp_lnk = 0; end
            else exp_lnk = 1;
        end else begin
            pend = pend | act;
            left = left - 1;
            if (left == 0) begin
                if (mode == 1) begin
                    mode = 2; left = T; exp_lnk = 1;
                end else if (pend) begin
                    mode = 1; left = T; pend = 0; exp_lnk = 0;
                end else begin
                    mode = 0; exp_lnk = 1;
                end
            end
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        vectors++;
        if (lnk_o !== exp_lnk) begin
            fails++;
            $display("FAIL %s lnk_led_drive_o actual=%b expected=%b at %0t", req, lnk_o, exp_lnk, $time);
        end
        if (spd_o !== exp_spd) begin
            fails++;
            $display("FAIL R8 spd_led_drive_o actual=%b expected=%b at %0t", spd_o, exp_spd, $time);
        end
        pat++;
        s100 = pat[1];
        aneg = pat[3];
        iso  = (pat % 7) == 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic strobe_tx();
        tx = 1'b1; cycle(); tx = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        req = "R1";
        run(3);
        rst_n = 1'b1;
        run(3);

        req = "R2";
        link = 1'b1;
        run(8);

        req = "R3";
        strobe_tx();
        run(T);

        req = "R6";
        run(3 * T);

        req = "R5";
        strobe_tx();
        run(2);
        rx = 1'b1; cycle(); rx = 1'b0;
        run(4 * T);
        strobe_tx();
        run(T + 1);
        rx = 1'b1; cycle(); rx = 1'b0;
        run(4 * T);

        req = "R4";
        tx = 1'b1;
        run(6 * T);
        tx = 1'b0;
        run(3 * T);

        req = "R7";
        strobe_tx();
        run(2);
        rx = 1'b1; cycle(); rx = 1'b0;
        link = 1'b0;
        run(3);
        link = 1'b1;
        run(3 * T);
        tx = 1'b1; run(T + 2); tx = 1'b0;
        link = 1'b0; run(2); link = 1'b1;
        run(3 * T);

        req = "R8";
        run(40);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule